// File: doc/BRIEF.md
# Serial Programming-Mode Entry Sequencer

This controller brings a target device into its serial programming mode. It sits above a separate byte transfer engine. A start strobe begins the entry. The block then requests a fixed four-byte enable command from the engine, one byte at a time. It collects the byte returned for each transfer and looks at the reply to the third transfer, which must echo the value 0x53. All four bytes are always sent before that reply is judged.

A correct echo ends the entry with a one-cycle done pulse. A wrong echo starts a recovery sequence. The engine enable is dropped, the target reset line gets one timed high pulse between two timed low gaps, and the engine enable is restored if the fast engine was selected at start. The command is then sent again. After a fixed number of failed attempts, the block gives a one-cycle error pulse at the end of the last recovery. It also gives a one-cycle pulse that tells the address logic to clear the high part of its extended address when a new entry begins.

Byte requests leave on a valid/ready stream. Valid rises only when a byte is due. Valid and data then stay unchanged, whatever the state of ready, until the cycle in which ready is high. Replies come back on a second valid/ready stream. Ready is high only while the block is waiting for the reply to the byte just sent. A reply offered at any other time is held off by a low ready.

Top module: `pgm_entry_seq`

## Requirements
- R1: A start pulse while idle is accepted at the next clock edge. In the cycle after that edge, hi_clr_o is high for exactly one cycle, eng_en_o equals fast_i as sampled at start, and the first byte request is valid. A start pulse while an entry is running is ignored and does not reload the attempt count.
- R2: Each attempt requests exactly four bytes in the order 0xAC, 0x53, 0x00, 0x00. While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o stays unchanged.
- R3: After a byte is accepted (tx_valid_o and tx_ready_i both high at an edge), tx_valid_o is low and rx_ready_o is high until a reply is taken (rx_valid_i and rx_ready_o both high). The next byte is requested in the cycle after that edge. tx_valid_o and rx_ready_o are never high together.
- R4: An attempt succeeds only when the reply to the third byte (position 2, counting from 0) equals 0x53. The value 0x53 in any other reply position has no effect. The fourth byte is sent even after a correct echo.
- R5: On success, done_o is high in the cycle right after the edge that takes the fourth reply. eng_en_o keeps the value chosen at start.
- R6: On failure, eng_en_o goes low in the cycle after the fourth reply. tgt_rst_o then stays low for GAP_CYCLES cycles, high for exactly GAP_CYCLES cycles, and low for GAP_CYCLES more. After that, eng_en_o returns to the value chosen at start and the next attempt's first byte is valid, 3*GAP_CYCLES+1 cycles after the fourth reply's edge.
- R7: When MAX_TRIES attempts have failed, err_o is high 3*GAP_CYCLES+1 cycles after the last fourth reply's edge, after one full reset pulse for that attempt. No further byte is requested.
- R8: done_o and err_o are single-cycle pulses and never high together. A new start after either one gets a full MAX_TRIES attempts.
- R9: While rst_n is low, and after it is released with no start, tx_valid_o, rx_ready_o, tgt_rst_o, eng_en_o, hi_clr_o, done_o and err_o are all low.
- R10: tgt_rst_o is never high while eng_en_o or tx_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an entry (used only while idle) |
| fast_i | input | 1 | Selects the fast engine; sampled at start |
| tx_valid_o | output | 1 | Byte request valid |
| tx_ready_i | input | 1 | Engine accepts the byte request |
| tx_data_o | output | 8 | Byte to transfer |
| rx_valid_i | input | 1 | Reply byte valid |
| rx_ready_o | output | 1 | Block waits for a reply |
| rx_data_i | input | 8 | Byte received during the transfer |
| tgt_rst_o | output | 1 | Target reset line drive |
| eng_en_o | output | 1 | Fast engine enable |
| hi_clr_o | output | 1 | Pulse: clear high part of extended address |
| done_o | output | 1 | Pulse: programming mode entered |
| err_o | output | 1 | Pulse: all attempts failed |

## Verification
Each result has a fixed cycle in which it is due. The start-side outputs are due one cycle after start is taken. Done is due one cycle after the fourth reply. The error pulse and the next attempt's first request are due 3*GAP_CYCLES+1 cycles after the fourth reply. The reset pulse width is exactly GAP_CYCLES. The bench drives every input at a falling edge and reads the outputs at the falling edge where they are due. It counts falling edges from the reply handshake to the next request or error and compares that count with the arithmetic value. It also checks at the next falling edge that each pulse has fallen again. A sweep over the attempt on which the echo first turns correct (including never), over both engine modes and over varied stall lengths covers every attempt count. A start pulse injected during a failing run shows that the attempt count is not reloaded.

// File: rtl/pes_pkg.sv
package pes_pkg;

  localparam int BYTE_W   = 8;
  localparam int CMD_LEN  = 4;
  localparam int IDX_W    = $clog2(CMD_LEN);
  localparam int ECHO_POS = 2;
  localparam logic [BYTE_W-1:0] ECHO_VAL = 8'h53;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_RECV,
    ST_GAP_A,
    ST_RST_HI,
    ST_GAP_B
  } pes_state_e;

  function automatic logic [BYTE_W-1:0] cmd_byte(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(0): cmd_byte = 8'hAC;
      IDX_W'(1): cmd_byte = 8'h53;
      default:   cmd_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/pes_gap_timer.sv
module pes_gap_timer #(
  parameter int GAP_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int TW = $clog2(GAP_CYCLES + 1);
  localparam logic [TW-1:0] RELOAD = TW'(GAP_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= RELOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pes_try_counter.sv
module pes_try_counter #(
  parameter int MAX_TRIES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic dec_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_TRIES + 1);
  localparam logic [CW-1:0] FULL = CW'(MAX_TRIES);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load_i) begin
      left_q <= FULL;
    end else if (dec_i && left_q != '0) begin
      left_q <= left_q - CW'(1);
    end
  end

  assign last_o = (left_q <= CW'(1));
endmodule

// File: rtl/pgm_entry_seq.sv
module pgm_entry_seq
  import pes_pkg::*;
#(
  parameter int MAX_TRIES  = 32,
  parameter int GAP_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       fast_i,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic [7:0] tx_data_o,
  input  logic       rx_valid_i,
  output logic       rx_ready_o,
  input  logic [7:0] rx_data_i,
  output logic       tgt_rst_o,
  output logic       eng_en_o,
  output logic       hi_clr_o,
  output logic       done_o,
  output logic       err_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CMD_LEN - 1);
  localparam logic [IDX_W-1:0] ECHO_IDX = IDX_W'(ECHO_POS);

  pes_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic             echo_ok_q;
  logic             fast_q;
  logic             rst_q, eng_q, hiclr_q, done_q, err_q;

  logic rx_take, last_reply, gap_exp, try_last;
  logic tmr_load, try_load, try_dec;

  assign rx_take    = (st_q == ST_RECV) && rx_valid_i;
  assign last_reply = rx_take && (idx_q == LAST_IDX);

  // Timer restarts on every entry into a recovery phase
  assign tmr_load = (last_reply && !echo_ok_q)
                  || ((st_q == ST_GAP_A)  && gap_exp)
                  || ((st_q == ST_RST_HI) && gap_exp);
  assign try_load = (st_q == ST_IDLE) && start_i;
  assign try_dec  = (st_q == ST_GAP_B) && gap_exp;

  pes_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .expired_o(gap_exp)
  );

  pes_try_counter #(.MAX_TRIES(MAX_TRIES)) u_try (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(try_load),
    .dec_i (try_dec),
    .last_o(try_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      echo_ok_q <= 1'b0;
      fast_q    <= 1'b0;
      rst_q     <= 1'b0;
      eng_q     <= 1'b0;
      hiclr_q   <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      hiclr_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q      <= ST_SEND;
            idx_q     <= '0;
            echo_ok_q <= 1'b0;
            fast_q    <= fast_i;
            eng_q     <= fast_i;
            hiclr_q   <= 1'b1;
          end
        end
        ST_SEND: begin
          if (tx_ready_i) st_q <= ST_RECV;
        end
        ST_RECV: begin
          if (rx_valid_i) begin
            if (idx_q == ECHO_IDX) echo_ok_q <= (rx_data_i == ECHO_VAL);
            if (idx_q == LAST_IDX) begin
              if (echo_ok_q) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                st_q  <= ST_GAP_A;
                eng_q <= 1'b0;
              end
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              st_q  <= ST_SEND;
            end
          end
        end
        ST_GAP_A: begin
          if (gap_exp) begin
            st_q  <= ST_RST_HI;
            rst_q <= 1'b1;
          end
        end
        ST_RST_HI: begin
          if (gap_exp) begin
            st_q  <= ST_GAP_B;
            rst_q <= 1'b0;
          end
        end
        ST_GAP_B: begin
          if (gap_exp) begin
            eng_q <= fast_q;
            if (try_last) begin
              st_q  <= ST_IDLE;
              err_q <= 1'b1;
            end else begin
              st_q      <= ST_SEND;
              idx_q     <= '0;
              echo_ok_q <= 1'b0;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid_o = (st_q == ST_SEND);
  assign tx_data_o  = cmd_byte(idx_q);
  assign rx_ready_o = (st_q == ST_RECV);
  assign tgt_rst_o  = rst_q;
  assign eng_en_o   = eng_q;
  assign hi_clr_o   = hiclr_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
endmodule

// File: rtl/pes_checker.sv
module pes_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic       rx_valid_i,
  input logic       rx_ready_o,
  input logic       tgt_rst_o,
  input logic       eng_en_o,
  input logic       hi_clr_o,
  input logic       done_o,
  input logic       err_o
);
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  p_tx_rx_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid_o && rx_ready_o));

  p_hiclr_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hi_clr_o |-> (tx_valid_o && $past(start_i)));

  p_hiclr_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hi_clr_o |=> !hi_clr_o);

  p_done_after_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(rx_valid_i && rx_ready_o));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  p_no_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  p_rst_safe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst_o |-> (!eng_en_o && !tx_valid_o));

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!tx_valid_o && !rx_ready_o && !tgt_rst_o));
endmodule

bind pgm_entry_seq pes_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i),
  .tx_data_o (tx_data_o),
  .rx_valid_i(rx_valid_i),
  .rx_ready_o(rx_ready_o),
  .tgt_rst_o (tgt_rst_o),
  .eng_en_o  (eng_en_o),
  .hi_clr_o  (hi_clr_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/pgm_entry_seq_bench.sv
module pgm_entry_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TRIES = 4;
  localparam int GAP = 3;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, fast_i = 1'b0;
  logic tx_ready_i = 1'b0, rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic tx_valid_o, rx_ready_o, tgt_rst_o, eng_en_o, hi_clr_o, done_o, err_o;
  logic [7:0] tx_data_o;

  int total = 0, bad = 0;
  int mon_total = 0, mon_bad = 0;
  int rst_pulses = 0, hi_width = 0;
  logic prev_rst = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgm_entry_seq #(.MAX_TRIES(TRIES), .GAP_CYCLES(GAP)) u_pgm_entry_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fast_i(fast_i),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
    .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o), .rx_data_i(rx_data_i),
    .tgt_rst_o(tgt_rst_o), .eng_en_o(eng_en_o), .hi_clr_o(hi_clr_o),
    .done_o(done_o), .err_o(err_o)
  );

  // Reset pulse monitor: width (R6) and safety (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (tgt_rst_o) begin
        hi_width = hi_width + 1;
        if (!prev_rst) rst_pulses = rst_pulses + 1;
        mon_total = mon_total + 1;
        if (eng_en_o || tx_valid_o) begin
          mon_bad = mon_bad + 1;
          $display("FAIL R10 rst high with en/valid: act=%0b%0b exp=00", eng_en_o, tx_valid_o);
        end
      end else if (prev_rst) begin
        mon_total = mon_total + 1;
        if (hi_width != GAP) begin
          mon_bad = mon_bad + 1;
          $display("FAIL R6 reset high width: act=%0d exp=%0d", hi_width, GAP);
        end
        hi_width = 0;
      end
      if (done_o && err_o) begin
        mon_total = mon_total + 1;
        mon_bad = mon_bad + 1;
        $display("FAIL R8 done and err together: act=11 exp=not both");
      end
      prev_rst = tgt_rst_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int b);
    case (b)
      0: exp_byte = 8'hAC;
      1: exp_byte = 8'h53;
      default: exp_byte = 8'h00;
    endcase
  endfunction

  task automatic serve(input int a, input int b, input int k, input bit inject);
    int stall = (a + b + k) % 3;
    int rdly = (a * b + k) % 2;
    logic [7:0] resp;
    chk(tx_valid_o == 1'b1, "R3", "byte request valid", tx_valid_o, 1);
    for (int s = 0; s < stall; s++) begin
      if (inject && s == 0) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(tx_valid_o && tx_data_o == exp_byte(b), "R2", "held under stall",
          tx_data_o, exp_byte(b));
    end
    chk(tx_data_o == exp_byte(b), "R2", "command byte", tx_data_o, exp_byte(b));
    tx_ready_i = 1'b1;
    @(negedge clk);
    tx_ready_i = 1'b0;
    chk(!tx_valid_o && rx_ready_o, "R3", "waiting for reply",
        {tx_valid_o, rx_ready_o}, 1);
    for (int d = 0; d < rdly; d++) @(negedge clk);
    if (b == 2) resp = (a == k) ? 8'h53 : 8'h10 + 8'(a);
    else resp = 8'h53;
    rx_valid_i = 1'b1;
    rx_data_i = resp;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic run_case(input int k, input bit fast);
    int base = rst_pulses;
    int c;
    fast_i = fast;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(hi_clr_o == 1'b1, "R1", "hi clear pulse", hi_clr_o, 1);
    chk(eng_en_o == fast, "R1", "engine enable at start", eng_en_o, fast);
    for (int a = 1; a <= TRIES; a++) begin
      for (int b = 0; b < 4; b++) serve(a, b, k, (k > TRIES) && a == 2 && b == 0);
      if (a == k) begin
        chk(done_o == 1'b1 && err_o == 1'b0, "R5", "done after fourth reply",
            done_o, 1);
        chk(eng_en_o == fast, "R5", "engine kept", eng_en_o, fast);
        chk(rst_pulses - base == k - 1, "R6", "reset pulses before success",
            rst_pulses - base, k - 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R8", "done single cycle", done_o, 0);
        return;
      end
      chk(done_o == 1'b0, "R4", "no done on wrong echo", done_o, 0);
      chk(eng_en_o == 1'b0, "R6", "engine off after failure", eng_en_o, 0);
      c = 1;
      while (!(tx_valid_o || err_o) && c < 200) begin
        @(negedge clk);
        c++;
      end
      chk(c == 3 * GAP + 1, (a == TRIES) ? "R7" : "R6", "recovery length",
          c, 3 * GAP + 1);
      chk(eng_en_o == fast, "R6", "engine restored", eng_en_o, fast);
      if (a == TRIES) begin
        chk(err_o == 1'b1 && tx_valid_o == 1'b0, "R7", "error after last try",
            err_o, 1);
        chk(rst_pulses - base == TRIES, "R7", "reset pulses on failure",
            rst_pulses - base, TRIES);
        @(negedge clk);
        chk(err_o == 1'b0, "R8", "err single cycle", err_o, 0);
        for (int q = 0; q < 4; q++) begin
          @(negedge clk);
          chk(tx_valid_o == 1'b0, "R7", "no request after error", tx_valid_o, 0);
        end
        return;
      end
      chk(err_o == 1'b0, "R6", "no error on retry", err_o, 0);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk({tx_valid_o, rx_ready_o, tgt_rst_o, eng_en_o, hi_clr_o, done_o, err_o} == 7'b0,
            "R9", "outputs in reset",
            {tx_valid_o, rx_ready_o, tgt_rst_o, eng_en_o, hi_clr_o, done_o, err_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({tx_valid_o, rx_ready_o, tgt_rst_o, eng_en_o, hi_clr_o, done_o, err_o} == 7'b0,
            "R9", "idle after reset",
            {tx_valid_o, rx_ready_o, tgt_rst_o, eng_en_o, hi_clr_o, done_o, err_o}, 0);
        for (int f = 0; f < 2; f++) begin
          for (int k = 1; k <= TRIES + 1; k++) begin
            run_case(k, f[0]);
            @(negedge clk);
          end
        end
      end
      begin
        repeat (WD_LIMIT) @(negedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: act=%0d exp<%0d cycles", WD_LIMIT, WD_LIMIT);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
    $finish;
  end
endmodule